// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block collects the interrupt conditions of a UART receiver and transmitter and reports only the single most urgent one. The report is a byte that host software reads from the identification register. The block also drives one active-high interrupt request line. It keeps the sticky state behind each source:

- a latched line-error flag;
- latched modem-line change flags;
- an armed transmit request;
- a receive inactivity counter that raises a character-timeout indication.

The surrounding bus decoder turns host reads of the line-status, identification and modem-status registers into one-cycle strobes. Those strobes clear the matching source.

The ranking, from most to least urgent, is as follows:

1. Line errors.
2. Receive data or receive timeout. These two share one level.
3. Transmit request.
4. Modem-line change.

Receive data and receive timeout report the same two-bit code. A separate bit tells them apart, and it is set only for the timeout case.

The inactivity timer is a three-state machine with these states:

- `TO_IDLE`: FIFO mode is off or the receive FIFO is empty.
- `TO_COUNT`: counting character times.
- `TO_FIRED`: the timeout indication is raised.

It has these transitions:

- `TO_IDLE` to `TO_COUNT` when FIFO mode is on and the FIFO holds data.
- `TO_COUNT` to `TO_FIRED` when the last cycle of the fourth silent character time ends.
- `TO_COUNT` or `TO_FIRED` back to `TO_IDLE` when the FIFO empties or FIFO mode is left.
- `TO_FIRED` to `TO_COUNT` on any push to or pop from the FIFO. A push or pop while in `TO_COUNT` restarts the count.

Top module: `uart_intr_ident`

## Requirements
- R1: After reset the identification byte reads 0x01 and `irq` is 0.
- R2: Bit 0 of `iir` is 0 exactly when an interrupt is reported, and `irq` is always its inverse.
- R3: Any set bit of `lsr_err` latches a line-status condition, reported with bits 2:1 = 11. An `rd_lsr` strobe clears it. If a new error arrives in the same cycle as the strobe, the error wins.
- R4: Receive-data condition, reported with bits 2:1 = 10 and bit 3 = 0. In FIFO mode it holds while `rx_level >= rx_trig`. In non-FIFO mode it follows `rhr_full`.
- R5: In FIFO mode with `rx_level` nonzero, `TO_CHARS`×`char_cycles` clock edges with no `rx_push` or `rx_pop` raise a timeout. The timeout reports bits 2:1 = 10 and bit 3 = 1. A push or pop clears it on the next edge. It never occurs in non-FIFO mode.
- R6: Transmit trigger. In FIFO mode the transmit condition is `tx_level <= FIFO_DEPTH/2`; in non-FIFO mode it is `thr_empty`. The request arms on the rising edge of this condition and is reported with bits 2:1 = 01. It drops when the condition goes false. An `rd_iir` strobe drops it only while `iir` shows code 01. A held condition does not re-arm the request.
- R7: Any change in any `modem_in` bit latches a modem condition, reported with bits 2:1 = 00. An `rd_msr` strobe clears it.
- R8: When several conditions are pending, the reported one is the first in this order: line status, then receive data or timeout, then transmit, then modem.
- R9: `ier` gates the sources: bit 0 gates receive data and timeout, bit 1 gates transmit, bit 2 gates line status and bit 3 gates modem. A disabled source is not reported, but its latched state is kept.
- R10: Bits 7:4 of `iir` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single-character mode |
| ier | input | 4 | Per-source enable mask |
| lsr_err | input | LSR_W | Line-error flags from the receiver |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| rhr_full | input | 1 | Receive holding register occupied (non-FIFO mode) |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | The host read the receive FIFO |
| char_cycles | input | CNT_W | Clock cycles per character time, at least 1 |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| thr_empty | input | 1 | Transmit holding register read out (non-FIFO mode) |
| modem_in | input | MODEM_W | Modem input lines |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-entry FIFO depth, which puts the transmit threshold at 8, and a four-character timeout. This makes the threshold boundary values 8, 9, 0 and 16 easy to reach. During the table phase `char_cycles` is held at 1000, so level-driven receive vectors never trip the timer. It is then lowered to 3, which gives a 12-edge window that can be probed one edge before and at the edge of expiry. The directed part also covers:

- a timeout re-firing and then combining with data-available;
- the error-wins collision on a line-status read;
- a transmit request surviving an identification read while receive data is shown.

// File: rtl/uart_intr_pkg.sv
package uart_intr_pkg;

    typedef enum logic [1:0] {
        ID_MODEM   = 2'b00,
        ID_TXEMPTY = 2'b01,
        ID_RXDATA  = 2'b10,
        ID_LINE    = 2'b11
    } irq_id_e;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;

endpackage

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_intr_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int CNT_W    = 16,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic [CNT_W-1:0] char_cycles,
    output logic             timeout
);
    localparam int CHR_W = (TO_CHARS > 1) ? $clog2(TO_CHARS) : 1;
    localparam logic [CHR_W-1:0] CHR_LAST = CHR_W'(TO_CHARS - 1);

    to_state_e        st, st_nxt;
    logic [CNT_W-1:0] cyc;
    logic [CHR_W-1:0] chr;
    logic             armed, activity, cyc_end, last_tick;

    assign armed     = fifo_mode && (rx_level != '0);
    assign activity  = rx_push || rx_pop;
    assign cyc_end   = (cyc == char_cycles - CNT_W'(1));
    assign last_tick = cyc_end && (chr == CHR_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TO_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            TO_IDLE:  if (armed) st_nxt = TO_COUNT;
            TO_COUNT: begin
                if (!armed)         st_nxt = TO_IDLE;
                else if (activity)  st_nxt = TO_COUNT;
                else if (last_tick) st_nxt = TO_FIRED;
            end
            TO_FIRED: begin
                if (!armed)        st_nxt = TO_IDLE;
                else if (activity) st_nxt = TO_COUNT;
            end
            default:  st_nxt = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
            chr <= '0;
        end else if (st != TO_COUNT || activity) begin
            cyc <= '0;
            chr <= '0;
        end else if (cyc_end) begin
            cyc <= '0;
            if (chr != CHR_LAST) chr <= chr + CHR_W'(1);
        end else begin
            cyc <= cyc + CNT_W'(1);
        end
    end

    always_comb begin
        timeout = (st == TO_FIRED);
    end

    p_activity_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !timeout);

    p_empty_no_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !timeout);

endmodule

// File: rtl/uart_modem_delta.sv
module uart_modem_delta #(
    parameter int MODEM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODEM_W-1:0] lines,
    input  logic               rd_clr,
    output logic               delta_any
);
    logic [MODEM_W-1:0] prev, delta;
    logic               primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev   <= '0;
            delta  <= '0;
            primed <= 1'b0;
        end else begin
            prev   <= lines;
            primed <= 1'b1;
            delta  <= (rd_clr ? '0 : delta) | (primed ? (lines ^ prev) : '0);
        end
    end

    assign delta_any = |delta;

    p_change_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && lines != prev) |=> delta_any);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && primed && $stable(lines)) |=> !delta_any);

endmodule

// File: rtl/uart_intr_ident.sv
module uart_intr_ident
    import uart_intr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 16,
    parameter int TO_CHARS   = 4,
    parameter int MODEM_W    = 4,
    parameter int LSR_W      = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode,
    input  logic [3:0]         ier,
    input  logic [LSR_W-1:0]   lsr_err,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   rx_trig,
    input  logic               rhr_full,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic [CNT_W-1:0]   char_cycles,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic               thr_empty,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               rd_lsr,
    input  logic               rd_iir,
    input  logic               rd_msr,
    output logic [7:0]         iir,
    output logic               irq
);
    localparam logic [LVL_W-1:0] TX_HALF = LVL_W'(FIFO_DEPTH / 2);

    logic    ls_hold, ms_any, to_raw, to_hit, rx_avail;
    logic    tx_cond, tx_cond_q, tx_pend, tx_ack;
    logic    pend, to_bit;
    irq_id_e id;

    uart_rx_timeout #(.LVL_W(LVL_W), .CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) u_timeout (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode   (fifo_mode),
        .rx_level    (rx_level),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .char_cycles (char_cycles),
        .timeout     (to_raw)
    );

    uart_modem_delta #(.MODEM_W(MODEM_W)) u_modem (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (modem_in),
        .rd_clr    (rd_msr),
        .delta_any (ms_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ls_hold <= 1'b0;
        else        ls_hold <= (rd_lsr ? 1'b0 : ls_hold) | (|lsr_err);
    end

    assign rx_avail = fifo_mode ? (rx_level >= rx_trig) : rhr_full;
    assign to_hit   = to_raw && fifo_mode;
    assign tx_cond  = fifo_mode ? (tx_level <= TX_HALF) : thr_empty;
    assign tx_ack   = rd_iir && pend && (id == ID_TXEMPTY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cond_q <= 1'b0;
            tx_pend   <= 1'b0;
        end else begin
            tx_cond_q <= tx_cond;
            if (!tx_cond)                    tx_pend <= 1'b0;
            else if (tx_cond && !tx_cond_q)  tx_pend <= 1'b1;
            else if (tx_ack)                 tx_pend <= 1'b0;
        end
    end

    always_comb begin
        pend   = 1'b1;
        to_bit = 1'b0;
        id     = ID_MODEM;
        if (ier[EN_LS] && ls_hold) begin
            id = ID_LINE;
        end else if (ier[EN_RX] && (rx_avail || to_hit)) begin
            id     = ID_RXDATA;
            to_bit = to_hit;
        end else if (ier[EN_TX] && tx_pend) begin
            id = ID_TXEMPTY;
        end else if (ier[EN_MS] && ms_any) begin
            id = ID_MODEM;
        end else begin
            pend = 1'b0;
        end
    end

    assign iir = {4'b0000, to_bit, id, ~pend};
    assign irq = pend;

    p_line_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[EN_LS] && ls_hold) |-> (iir[2:1] == 2'b11 && !iir[0]));

    p_timeout_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iir[3] |-> (iir[2:1] == 2'b10 && fifo_mode && !iir[0]));

    p_ls_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && lsr_err == '0) |=> !ls_hold);

    p_tx_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && iir[3:0] == 4'b0010) |=> !tx_pend);

endmodule

// File: tb/tb_uart_intr_ident.sv
`timescale 1ns/1ps
module tb_uart_intr_ident;

    logic       clk, rst_n;
    logic       fifo_mode;
    logic [3:0] ier;
    logic [3:0] lsr_err;
    logic [4:0] rx_level, rx_trig, tx_level;
    logic       rhr_full, rx_push, rx_pop, thr_empty;
    logic [15:0] char_cycles;
    logic [3:0] modem_in;
    logic       rd_lsr, rd_iir, rd_msr;
    logic [7:0] iir;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    uart_intr_ident dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ier(ier),
        .lsr_err(lsr_err), .rx_level(rx_level), .rx_trig(rx_trig),
        .rhr_full(rhr_full), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_cycles(char_cycles), .tx_level(tx_level), .thr_empty(thr_empty),
        .modem_in(modem_in), .rd_lsr(rd_lsr), .rd_iir(rd_iir), .rd_msr(rd_msr),
        .iir(iir), .irq(irq)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct packed {
        logic       fm;
        logic [3:0] en;
        logic [4:0] lvl;
        logic [4:0] trig;
        logic       rhr;
        logic [7:0] exp;
    } vec_t;

    // R4 / R9 receive-data vectors: {fifo_mode, ier, rx_level, rx_trig, rhr_full, expected iir}
    localparam vec_t VECS [10] = '{
        '{1'b1, 4'hF, 5'd0,  5'd4,  1'b0, 8'h01},
        '{1'b1, 4'hF, 5'd3,  5'd4,  1'b0, 8'h01},
        '{1'b1, 4'hF, 5'd4,  5'd4,  1'b0, 8'h04},
        '{1'b1, 4'hF, 5'd9,  5'd8,  1'b0, 8'h04},
        '{1'b1, 4'hE, 5'd4,  5'd4,  1'b0, 8'h01},
        '{1'b0, 4'hF, 5'd4,  5'd4,  1'b0, 8'h01},
        '{1'b0, 4'hF, 5'd0,  5'd4,  1'b1, 8'h04},
        '{1'b1, 4'hF, 5'd0,  5'd1,  1'b1, 8'h01},
        '{1'b1, 4'hF, 5'd14, 5'd14, 1'b0, 8'h04},
        '{1'b0, 4'h0, 5'd0,  5'd4,  1'b1, 8'h01}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: iir actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input string req, input logic exp);
        n_chk++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", req, irq, exp);
        end
    endtask

    task automatic pulse_lsr(); rd_lsr = 1'b1; tick(1); rd_lsr = 1'b0; endtask
    task automatic pulse_msr(); rd_msr = 1'b1; tick(1); rd_msr = 1'b0; endtask
    task automatic pulse_iir(); rd_iir = 1'b1; tick(1); rd_iir = 1'b0; endtask

    initial begin
        #(5.0 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fifo_mode = 1'b1; ier = 4'hF; lsr_err = '0;
        rx_level = '0; rx_trig = 5'd4; rhr_full = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
        char_cycles = 16'd1000; tx_level = 5'd16; thr_empty = 1'b0; modem_in = '0;
        rd_lsr = 1'b0; rd_iir = 1'b0; rd_msr = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset value", iir, 8'h01);
        chk_irq("R1 reset irq", 1'b0);

        // table walk: R4 receive data, R9 masking
        for (int i = 0; i < 10; i++) begin
            fifo_mode = VECS[i].fm; ier = VECS[i].en; rx_level = VECS[i].lvl;
            rx_trig = VECS[i].trig; rhr_full = VECS[i].rhr;
            tick(1);
            chk("R4/R9 vector", iir, VECS[i].exp);
            chk_irq("R2 vector irq", ~VECS[i].exp[0]);
        end
        fifo_mode = 1'b1; ier = 4'hF; rx_level = '0; rx_trig = 5'd4; rhr_full = 1'b0;
        tick(1);
        chk("R10 idle", iir, 8'h01);

        // R6 transmit request
        tx_level = 5'd8; tick(1);
        chk("R6 arm at half", iir, 8'h02);
        chk_irq("R2 tx irq", 1'b1);
        pulse_iir();
        chk("R6 ack by read", iir, 8'h01);
        tick(2);
        chk("R6 no rearm while held", iir, 8'h01);
        tx_level = 5'd12; tick(1); tx_level = 5'd8; tick(1);
        chk("R6 rearm", iir, 8'h02);
        tx_level = 5'd9; tick(1);
        chk("R6 above half drops", iir, 8'h01);
        tx_level = 5'd0; tick(1);
        chk("R6 empty arms", iir, 8'h02);
        tx_level = 5'd16; tick(1);
        chk("R6 full drops", iir, 8'h01);
        fifo_mode = 1'b0; tx_level = 5'd0; tick(1);
        chk("R6 level ignored non-FIFO", iir, 8'h01);
        thr_empty = 1'b1; tick(1);
        chk("R6 non-FIFO holding empty", iir, 8'h02);
        thr_empty = 1'b0; tick(1);
        chk("R6 non-FIFO drop", iir, 8'h01);
        fifo_mode = 1'b1; tx_level = 5'd16; tick(1);

        // R7 modem change
        modem_in = 4'b0010; tick(1);
        chk("R7 modem rise", iir, 8'h00);
        chk_irq("R2 modem irq", 1'b1);
        tick(2);
        chk("R7 sticky", iir, 8'h00);
        pulse_msr();
        chk("R7 read clears", iir, 8'h01);
        modem_in = 4'b0000; tick(1);
        chk("R7 modem fall", iir, 8'h00);
        pulse_msr();
        chk("R7 read clears again", iir, 8'h01);

        // R3 line status and R8 ordering
        lsr_err = 4'b0100; modem_in = 4'b1000; tick(1); lsr_err = '0;
        chk("R8 line over modem", iir, 8'h06);
        pulse_lsr();
        chk("R3 read clears, modem shown", iir, 8'h00);
        pulse_msr();
        chk("R7 cleared", iir, 8'h01);
        rd_lsr = 1'b1; lsr_err = 4'b0001; tick(1); rd_lsr = 1'b0; lsr_err = '0;
        chk("R3 error wins over read", iir, 8'h06);
        pulse_lsr();
        chk("R3 cleared", iir, 8'h01);

        // R8 receive over transmit, R6 read while receive shown
        tx_level = 5'd8; tick(1);
        rx_level = 5'd4; tick(1);
        chk("R8 rx over tx", iir, 8'h04);
        pulse_iir();
        chk("R8 rx still shown", iir, 8'h04);
        rx_level = 5'd0; tick(1);
        chk("R6 not acked under rx", iir, 8'h02);
        pulse_iir();
        chk("R6 acked", iir, 8'h01);
        tx_level = 5'd16;
        rx_level = 5'd4; lsr_err = 4'b1000; tick(1); lsr_err = '0;
        chk("R8 line over rx", iir, 8'h06);
        pulse_lsr();
        chk("R8 rx after line read", iir, 8'h04);
        rx_level = 5'd0; tick(1);
        chk("R4 rx drop", iir, 8'h01);

        // R9 enable masking keeps latched state
        ier = 4'h0; lsr_err = 4'b0010; modem_in = 4'b0001; tick(1); lsr_err = '0;
        chk("R9 all masked", iir, 8'h01);
        chk_irq("R9 irq masked", 1'b0);
        ier = 4'b0100; tick(1);
        chk("R9 line unmasked", iir, 8'h06);
        ier = 4'b1000; tick(1);
        chk("R9 modem unmasked", iir, 8'h00);
        pulse_lsr(); pulse_msr(); ier = 4'hF; tick(1);
        chk("R9 restored idle", iir, 8'h01);

        // R5 character timeout
        char_cycles = 16'd3; rx_level = 5'd1;
        rx_push = 1'b1; tick(1); rx_push = 1'b0;
        tick(11);
        chk("R5 one edge early", iir, 8'h01);
        tick(1);
        chk("R5 timeout fires", iir, 8'h0C);
        chk_irq("R2 timeout irq", 1'b1);
        ier = 4'hE; tick(1);
        chk("R9 timeout masked", iir, 8'h01);
        ier = 4'hF; tick(1);
        chk("R5 still pending", iir, 8'h0C);
        rx_pop = 1'b1; tick(1); rx_pop = 1'b0;
        chk("R5 pop clears", iir, 8'h01);
        tick(12);
        chk("R5 refires", iir, 8'h0C);
        rx_level = 5'd4; tick(1);
        chk("R5 with data available", iir, 8'h0C);
        rx_level = 5'd0; tick(1);
        chk("R5 empty clears", iir, 8'h01);
        fifo_mode = 1'b0; rx_level = 5'd1; tick(20);
        chk("R5 none in non-FIFO", iir, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule